// File: doc/BRIEF.md
# Paged Wiper Register Write Controller

This block sits behind a serial front end that has already turned a bus transaction into simple strobes: a start strobe carrying a page and a starting slot, a stream of data bytes, and a stop strobe. It holds a nonvolatile array of four pages with four slots each, one slot per wiper, plus four volatile wiper registers that drive the wiper outputs and a status register with a single nonvolatile-enable bit.

Slots belong to wipers in a fixed order that is not linear: slot 0 is wiper 0A, slot 1 is wiper 1B, slot 2 is wiper 1A and slot 3 is wiper 0B. Incoming bytes fill a page buffer starting at the given slot. The pointer steps through the slots and wraps within the page. On stop the buffered bytes are committed to the array, provided the enable bit is set and write protection is off. Every wiper register is then reloaded from the page, and a modelled write cycle keeps the block busy for a fixed number of cycles. If the commit is refused, the buffer is thrown away and nothing changes.

Top module: `pageWiperCtl`

## Requirements
- R1: After reset every array entry, every wiper register and the enable bit read 0, and busy and byteAck are low.
- R2: A pulse on statusWe while not busy loads statusIn into the enable bit, which is visible on nvEnable after the next clock edge.
- R3: wiperBus lane i (bits 8*i+7 down to 8*i) carries the wiper register of slot i, with slot 0=0A, 1=1B, 2=1A and 3=0B. rdData returns the array entry at rdPage and rdSlot combinationally.
- R4: Every byte accepted during an open transaction raises byteAck for exactly the cycle after the edge that accepted it. A byte that arrives with no open transaction is ignored and is not acknowledged.
- R5: After each accepted byte the slot pointer (curSlot) advances by one and wraps from 3 to 0, while the page stays fixed. For example, three bytes starting at slot 2 of page 2 land in slots 2, 3 and 0, and curSlot then reads 1.
- R6: When more than four bytes are sent, later bytes overwrite the buffered slots in the wrapped order, and the last byte written to each slot is the one that is committed.
- R7: A stop with the enable bit at 0 discards the buffer. The array and the wiper registers are unchanged and busy stays low.
- R8: A stop with wpN low discards the buffer. The array and the wiper registers are unchanged and busy stays low.
- R9: On a committed stop, each slot that received a byte is written into the array at that page, and each wiper register takes that byte. A wiper whose slot received no byte is reloaded from the page's existing array entry.
- R10: After a committed stop, busy is high for exactly BUSY_CYCLES cycles. While busy is high, start, byte, stop and status inputs are ignored and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | Opens a write transaction |
| wrPage | input | 2 | Page address, sampled with wrStart |
| wrSlot | input | 2 | Starting slot, sampled with wrStart |
| byteValid | input | 1 | Data byte present |
| byteData | input | 8 | Data byte |
| byteAck | output | 1 | Acknowledge for the byte accepted at the previous edge |
| wrStop | input | 1 | Ends the transaction and requests the commit |
| wpN | input | 1 | Write-protect, active low, sampled at stop |
| statusWe | input | 1 | Status register write strobe |
| statusIn | input | 1 | New enable bit value |
| nvEnable | output | 1 | Current enable bit |
| busy | output | 1 | Modelled nonvolatile write cycle in progress |
| curSlot | output | 2 | Current slot pointer |
| rdPage | input | 2 | Read page select |
| rdSlot | input | 2 | Read slot select |
| rdData | output | 8 | Array entry at rdPage and rdSlot |
| wiperBus | output | 32 | Four wiper registers, lane i is slot i |

## Verification
The embedded assertions check four things on every cycle. No acknowledge appears while busy, and every acknowledge follows a byte. The page stays put while bytes arrive. Busy starts right after a commit, and neither the array nor the wiper registers move on any cycle without a commit. Other behaviours depend on whole transactions, so only the bench scenarios can show them: the wrapped slot order, overwriting past four bytes, the reload of wipers whose slots were not written, refusal when the enable bit is off or protection is on, and the exact length of the busy period.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic commit;
    logic statusWr;
  } ctlStrobes_t;
endpackage

// File: rtl/pwcControl.sv
module pwcControl
  import pwc_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStart,
  input  logic        byteValid,
  input  logic        wrStop,
  input  logic        wpN,
  input  logic        statusWe,
  input  logic        nvEn,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        byteAck
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic             loading;
  logic             idleOk;
  logic             stopTaken;

  always_comb begin
    idleOk            = (busyCnt == '0);
    strobes.loadAddr  = wrStart && idleOk;
    strobes.storeByte = byteValid && loading && idleOk && !wrStart;
    stopTaken         = wrStop && loading && idleOk && !wrStart && !byteValid;
    strobes.commit    = stopTaken && nvEn && wpN;
    strobes.statusWr  = statusWe && idleOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      loading <= 1'b0;
      byteAck <= 1'b0;
    end else begin
      byteAck <= strobes.storeByte;
      if (strobes.loadAddr)  loading <= 1'b1;
      else if (stopTaken)    loading <= 1'b0;
      if (strobes.commit)    busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (!idleOk)      busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = !idleOk;

  a_r10_no_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !byteAck);
  a_r4_ack_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    byteAck |-> $past(byteValid));
  a_r10_busy_starts: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> busy);
endmodule

// File: rtl/pwcDatapath.sv
module pwcDatapath
  import pwc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 4,
  parameter int NUM_SLOTS = 4,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobes_t                   strobes,
  input  logic [PAGE_W-1:0]             inPage,
  input  logic [SLOT_W-1:0]             inSlot,
  input  logic [DATA_W-1:0]             byteData,
  input  logic                          statusIn,
  input  logic [PAGE_W-1:0]             rdPage,
  input  logic [SLOT_W-1:0]             rdSlot,
  output logic                          nvEn,
  output logic [SLOT_W-1:0]             slotPtr,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_SLOTS*DATA_W-1:0]   wiperBus
);
  logic [NUM_PAGES-1:0][NUM_SLOTS-1:0][DATA_W-1:0] nvArray;
  logic [NUM_SLOTS-1:0][DATA_W-1:0]                pageBuf;
  logic [NUM_SLOTS-1:0]                            bufValid;
  logic [NUM_SLOTS-1:0][DATA_W-1:0]                wiperReg;
  logic [PAGE_W-1:0]                               pagePtr;
  logic [SLOT_W-1:0]                               nextSlot;

  assign nextSlot = (slotPtr == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slotPtr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nvArray  <= '0;
      pageBuf  <= '0;
      bufValid <= '0;
      wiperReg <= '0;
      pagePtr  <= '0;
      slotPtr  <= '0;
      nvEn     <= 1'b0;
    end else begin
      if (strobes.statusWr) nvEn <= statusIn;
      if (strobes.loadAddr) begin
        pagePtr  <= inPage;
        slotPtr  <= inSlot;
        bufValid <= '0;
      end
      if (strobes.storeByte) begin
        pageBuf[slotPtr]  <= byteData;
        bufValid[slotPtr] <= 1'b1;
        slotPtr           <= nextSlot;
      end
      if (strobes.commit) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          if (bufValid[s]) begin
            nvArray[pagePtr][s] <= pageBuf[s];
            wiperReg[s]         <= pageBuf[s];
          end else begin
            wiperReg[s]         <= nvArray[pagePtr][s];
          end
        end
      end
    end
  end

  assign rdData = nvArray[rdPage][rdSlot];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gLane
    assign wiperBus[g*DATA_W +: DATA_W] = wiperReg[g];
  end

  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte |=> $stable(pagePtr));
  a_r7_array_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(nvArray));
  a_r9_wiper_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(wiperReg));
  a_r6_valid_grows: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte |=> $countones(bufValid) >= $countones($past(bufValid)));
endmodule

// File: rtl/pageWiperCtl.sv
module pageWiperCtl
  import pwc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_PAGES   = 4,
  parameter int NUM_SLOTS   = 4,
  parameter int BUSY_CYCLES = 16,
  localparam int PAGE_W     = $clog2(NUM_PAGES),
  localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrStart,
  input  logic [PAGE_W-1:0]           wrPage,
  input  logic [SLOT_W-1:0]           wrSlot,
  input  logic                        byteValid,
  input  logic [DATA_W-1:0]           byteData,
  output logic                        byteAck,
  input  logic                        wrStop,
  input  logic                        wpN,
  input  logic                        statusWe,
  input  logic                        statusIn,
  output logic                        nvEnable,
  output logic                        busy,
  output logic [SLOT_W-1:0]           curSlot,
  input  logic [PAGE_W-1:0]           rdPage,
  input  logic [SLOT_W-1:0]           rdSlot,
  output logic [DATA_W-1:0]           rdData,
  output logic [NUM_SLOTS*DATA_W-1:0] wiperBus
);
  ctlStrobes_t strobes;

  pwcControl #(.BUSY_CYCLES(BUSY_CYCLES)) i_control (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .byteValid(byteValid),
    .wrStop(wrStop), .wpN(wpN), .statusWe(statusWe), .nvEn(nvEnable),
    .strobes(strobes), .busy(busy), .byteAck(byteAck)
  );

  pwcDatapath #(.DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .NUM_SLOTS(NUM_SLOTS)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inPage(wrPage), .inSlot(wrSlot),
    .byteData(byteData), .statusIn(statusIn), .rdPage(rdPage), .rdSlot(rdSlot),
    .nvEn(nvEnable), .slotPtr(curSlot), .rdData(rdData), .wiperBus(wiperBus)
  );
endmodule

// File: tb/test_pageWiperCtl.sv
module test_pageWiperCtl;
  localparam int BUSY = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStart = 0, byteValid = 0, wrStop = 0, wpN = 1, statusWe = 0, statusIn = 0;
  logic [1:0] wrPage = 0, wrSlot = 0, rdPage = 0, rdSlot = 0, curSlot;
  logic [7:0] byteData = 0, rdData;
  logic byteAck, nvEnable, busy;
  logic [31:0] wiperBus;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] expArr [4][4];
  logic [7:0] expWip [4];
  logic expEn = 0;

  always #2.5 clk = ~clk;

  pageWiperCtl i_pageWiperCtl (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrPage(wrPage), .wrSlot(wrSlot),
    .byteValid(byteValid), .byteData(byteData), .byteAck(byteAck), .wrStop(wrStop),
    .wpN(wpN), .statusWe(statusWe), .statusIn(statusIn), .nvEnable(nvEnable),
    .busy(busy), .curSlot(curSlot), .rdPage(rdPage), .rdSlot(rdSlot),
    .rdData(rdData), .wiperBus(wiperBus)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic verifyAll(input string tag);
    for (int s = 0; s < 4; s++)
      chk(wiperBus[s*8 +: 8] == expWip[s], {tag, " R3 wiper lane"}, wiperBus[s*8 +: 8], expWip[s]);
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        rdPage = 2'(p); rdSlot = 2'(s);
        #1;
        chk(rdData == expArr[p][s], {tag, " R3 array entry"}, rdData, expArr[p][s]);
      end
  endtask

  task automatic setStatus(input logic v);
    @(negedge clk); statusWe = 1; statusIn = v;
    @(posedge clk); #1;
    expEn = v;
    chk(nvEnable == v, "R2 enable write", nvEnable, v);
    @(negedge clk); statusWe = 0;
  endtask

  function automatic logic [1:0] wrapSlot(input int s);
    return 2'(s % 4);
  endfunction

  // Runs a full transaction; when bytes are given as 0..255 they are used, else random.
  task automatic runTxn(input int page, input int slot, input int n, input logic wp, input int fixedData);
    logic [7:0] bufM [4];
    bit bufV [4];
    int cnt;
    for (int s = 0; s < 4; s++) bufV[s] = 0;
    @(negedge clk); wrStart = 1; wrPage = 2'(page); wrSlot = 2'(slot);
    @(posedge clk);
    @(negedge clk); wrStart = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = (fixedData >= 0) ? 8'(fixedData + i) : 8'($urandom);
      @(negedge clk); byteValid = 1; byteData = d;
      @(posedge clk); #1;
      chk(byteAck == 1'b1, "R4 byte acked", byteAck, 1);
      bufM[(slot + i) % 4] = d; bufV[(slot + i) % 4] = 1;
      chk(curSlot == wrapSlot(slot + i + 1), "R5 slot advance", curSlot, wrapSlot(slot + i + 1));
      @(negedge clk); byteValid = 0;
      @(posedge clk); #1;
      chk(byteAck == 1'b0, "R4 ack single cycle", byteAck, 0);
    end
    @(negedge clk); wrStop = 1; wpN = wp;
    @(posedge clk); #1;
    if (expEn && wp) begin
      for (int s = 0; s < 4; s++) begin
        if (bufV[s]) begin expArr[page][s] = bufM[s]; expWip[s] = bufM[s]; end
        else expWip[s] = expArr[page][s];
      end
      chk(busy == 1'b1, "R10 busy after commit", busy, 1);
      @(negedge clk); wrStop = 0; wpN = 1;
      cnt = 1;
      while (busy && cnt < 1000) begin @(posedge clk); #1; if (busy) cnt++; end
      chk(cnt == BUSY, "R10 busy length", cnt, BUSY);
    end else begin
      chk(busy == 1'b0, expEn ? "R8 protected no busy" : "R7 disabled no busy", busy, 0);
      @(negedge clk); wrStop = 0; wpN = 1;
    end
    verifyAll(expEn && wp ? "R9 commit" : (expEn ? "R8 discard" : "R7 discard"));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int p = 0; p < 4; p++) for (int s = 0; s < 4; s++) expArr[p][s] = 0;
    for (int s = 0; s < 4; s++) expWip[s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(byteAck == 0, "R1 reset ack", byteAck, 0);
    chk(nvEnable == 0, "R1 reset enable", nvEnable, 0);
    verifyAll("R1 reset");

    // R7: enable bit clear, write refused
    runTxn(1, 0, 4, 1, 8'h40);
    setStatus(1);
    // R8: protected write refused
    runTxn(1, 0, 4, 0, 8'h50);
    // R9: full page
    runTxn(2, 0, 4, 1, 8'h10);
    // R5: three bytes from slot 2 of page 2 -> slots 2,3,0; pointer then at 1
    runTxn(2, 2, 3, 1, 8'hA0);
    chk(curSlot == 2'd1, "R5 pointer rests at slot 1", curSlot, 1);
    // R6: six bytes wrap and overwrite
    runTxn(3, 3, 6, 1, 8'hC0);

    // R4: byte with no open transaction ignored
    @(negedge clk); byteValid = 1; byteData = 8'hEE;
    @(posedge clk); #1;
    chk(byteAck == 0, "R4 stray byte not acked", byteAck, 0);
    @(negedge clk); byteValid = 0;

    // R10: inputs ignored while busy
    runTxn(0, 1, 1, 1, 8'h77);
    @(negedge clk); wrStart = 1; wrPage = 0; wrSlot = 0;
    @(posedge clk);
    @(negedge clk); wrStart = 0; wrStop = 1;
    @(posedge clk); #1;
    chk(busy == 1, "R10 busy after commit", busy, 1);
    @(negedge clk); wrStop = 0; statusWe = 1; statusIn = 0; byteValid = 1; byteData = 8'h33; wrStart = 1;
    @(posedge clk); #1;
    chk(byteAck == 0, "R10 no ack while busy", byteAck, 0);
    @(negedge clk); statusWe = 0; byteValid = 0; wrStart = 0;
    while (busy) @(posedge clk);
    #1;
    chk(nvEnable == 1, "R10 status write ignored while busy", nvEnable, 1);
    @(negedge clk); byteValid = 1; byteData = 8'h55;
    @(posedge clk); #1;
    chk(byteAck == 0, "R10 start during busy ignored", byteAck, 0);
    @(negedge clk); byteValid = 0;
    for (int s = 0; s < 4; s++) expWip[s] = expArr[0][s];
    verifyAll("R10 after busy");

    // constrained random
    for (int t = 0; t < 40; t++) begin
      if (($urandom % 8) == 0) setStatus(1'($urandom % 2));
      runTxn(int'($urandom % 4), int'($urandom % 4), int'($urandom % 7),
             (($urandom % 4) != 0), -1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule